// File: doc/BRIEF.md
# Alarm and Periodic Interrupt Controller

This block merges three interrupt sources of a real-time clock into one active-low interrupt line. The sources are a masked alarm comparison, a programmable periodic timer and a power-fail event. Each source sets its own sticky flag. Each flag is gated by its own enable bit. When the block is used in the interrupt path, software sees the flag byte, and one read strobe clears every event flag at once.

The alarm compares the current seconds, minutes, hours and date bytes with four alarm bytes. The comparison runs once on each update pulse. Any alarm byte can be left out of the comparison, which sets how often the alarm repeats. The periodic timer counts ticks of a 32.768 kHz clock-enable. The power-fail source reacts to the rising edge of a supply-fail input. The interrupt output is an open-drain pull-down enable. In backup mode it is released unless an alarm occurs and alarm-in-backup is enabled.

Clock counting and register bus decoding belong to neighbouring blocks.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: An alarm byte is left out of the comparison exactly when its bits 7 and 6 are both 1. An alarm byte that is not left out must equal all 8 bits of its current byte.
- R2: On a cycle with `upd_pulse` high, the alarm flag (flags bit 3) is set from the next cycle when every byte that is not left out matches. Without an update pulse the alarm flag does not set.
- R3: A rate code n from 1 to 15 sets the periodic flag (flags bit 2) on every 2^(n-1)-th tick. Counting starts from the first tick after the code leaves 0.
- R4: Rate code 0 never sets the periodic flag and holds the tick count at its start.
- R5: The power-fail flag (flags bit 1) is set only on a rising edge of `pwr_fail`. Holding `pwr_fail` high does not set the flag again after it has been cleared.
- R6: Flags bit 0 follows `batt_valid`, is not cleared by a read, and flags bits 7 to 4 read 0.
- R7: A cycle with `flag_rd` high clears flags bits 3 to 1 from the next cycle. A source whose event occurs in that same cycle keeps its flag set.
- R8: Outside backup mode, `irq_pull` is 1 exactly when some flag among alarm, periodic and power-fail is set together with its enable bit.
- R9: In backup mode, `irq_pull` is 1 only when the alarm flag, `en_alarm` and `en_alm_backup` are all set.
- R10: After reset, flags bits 3 to 1 are 0 and `irq_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz period |
| upd_pulse | input | 1 | Once-per-second time update strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current date, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD with mask bits 7:6 |
| alm_min | input | 8 | Alarm minutes, BCD with mask bits 7:6 |
| alm_hour | input | 8 | Alarm hours, BCD with mask bits 7:6 |
| alm_date | input | 8 | Alarm date, BCD with mask bits 7:6 |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_pwrfail | input | 1 | Power-fail interrupt enable |
| en_alm_backup | input | 1 | Alarm interrupt allowed in backup mode |
| pwr_fail | input | 1 | Supply below fail threshold |
| backup_mode | input | 1 | Running from backup supply |
| batt_valid | input | 1 | Battery-valid status |
| flag_rd | input | 1 | Flag byte read strobe, clears events |
| flags | output | 8 | Flag byte {0000, alarm, periodic, power-fail, battery-valid} |
| irq_pull | output | 1 | 1 = drive interrupt line low, 0 = high impedance |

## Verification
A wrong mask decode or comparator bit shows up on flags bit 3 in the cycle after the update pulse. A drifting periodic counter moves the first set of flags bit 2 away from the 2^(n-1)-th tick, and the widest code only shows this after 16384 ticks. A stuck or lost flag, or a read-clear race resolved the wrong way, shows up on the flag byte one cycle after the read. A wrong gating term shows up at once on `irq_pull`, either with enables cleared or in backup mode.

// File: rtl/rtc_irq_pkg.sv
// Shared constants and helpers for the RTC interrupt controller.
// Assumes BCD time bytes and a 4-bit periodic rate code.
package rtc_irq_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_ALM   = 4;
    localparam int RATE_W    = 4;
    // Largest period is 2^(2^RATE_W - 2) ticks; one extra bit of headroom.
    localparam int PER_CNT_W = (1 << RATE_W) - 1;

    // Flag byte bit positions.
    localparam int FLAG_ALM = 3;
    localparam int FLAG_PER = 2;
    localparam int FLAG_PWR = 1;
    localparam int FLAG_BAT = 0;

    typedef struct packed {
        logic alm;
        logic per;
        logic pwr;
    } irq_evt_t;

    // Terminal count for rate code (code >= 1): 2^(code-1) - 1.
    function automatic logic [PER_CNT_W-1:0] per_limit(input logic [RATE_W-1:0] code);
        logic [PER_CNT_W-1:0] one;
        one = {{(PER_CNT_W-1){1'b0}}, 1'b1};
        return (one << (code - 1'b1)) - one;
    endfunction
endpackage

// File: rtl/rtc_alarm_match.sv
// Masked alarm comparator.
// Each alarm byte takes part in the comparison unless its two top bits are
// both 1. The event is produced combinationally in the update-pulse cycle.
// Assumes the update pulse lasts one clock cycle.
module rtc_alarm_match
    import rtc_irq_pkg::*;
#(
    parameter int NB = NUM_ALM,
    parameter int W  = BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_pulse,
    input  logic [NB-1:0][W-1:0] cur_bytes,
    input  logic [NB-1:0][W-1:0] alm_bytes,
    output logic                 alm_evt
);
    localparam int MSB = W - 1;
    localparam int MID = W - 2;

    logic [NB-1:0] byte_skip;
    logic [NB-1:0] byte_ok;

    // Per-byte mask decode and compare.
    for (genvar gi = 0; gi < NB; gi++) begin : g_byte
        assign byte_skip[gi] = alm_bytes[gi][MSB] & alm_bytes[gi][MID];
        assign byte_ok[gi]   = byte_skip[gi] | (alm_bytes[gi] == cur_bytes[gi]);
    end

    // An alarm event needs an update and every active byte matching.
    always_comb begin
        alm_evt = upd_pulse & (&byte_ok);
    end

    // R1: a fully masked alarm always matches on an update.
    p_all_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && (&byte_skip)) |-> alm_evt);
    // R2: no alarm event without an update pulse.
    p_evt_needs_upd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt |-> upd_pulse);
endmodule

// File: rtl/rtc_periodic_timer.sv
// Periodic interrupt timer.
// Counts 32.768 kHz ticks and fires once every 2^(code-1) ticks for a
// nonzero rate code. Code 0 halts the timer and holds the count at zero.
// Assumes tick_32k is a single-cycle enable.
module rtc_periodic_timer
    import rtc_irq_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int CW = PER_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_32k,
    input  logic [RW-1:0] rate_sel,
    output logic          per_evt
);
    logic [CW-1:0] tick_cnt;
    logic [CW-1:0] limit;
    logic          run;

    // Terminal count for the selected rate.
    always_comb begin
        run     = (rate_sel != '0);
        limit   = per_limit(rate_sel);
        per_evt = run & tick_32k & (tick_cnt >= limit);
    end

    // Tick counter; restarts on each period and while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tick_cnt <= '0;
        end else if (tick_32k) begin
            if (tick_cnt >= limit) tick_cnt <= '0;
            else                   tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // R3: after a period ends, counting restarts at zero.
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> (tick_cnt == '0));
    // R4: code 0 keeps the count at zero.
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> (tick_cnt == '0));
endmodule

// File: rtl/rtc_flag_irq.sv
// Event flags and interrupt gating.
// Holds the alarm, periodic and power-fail flags. A read strobe clears all
// three, but an event in the same cycle keeps its flag set. Also detects
// the rising edge of power-fail and drives the open-drain pull enable.
// Assumes pwr_fail is already synchronous to clk.
module rtc_flag_irq
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alm_evt,
    input  logic       per_evt,
    input  logic       pwr_fail,
    input  logic       flag_rd,
    input  logic       en_alarm,
    input  logic       en_periodic,
    input  logic       en_pwrfail,
    input  logic       en_alm_backup,
    input  logic       backup_mode,
    output irq_evt_t   flag_q,
    output logic       irq_pull
);
    logic     pwr_prev;
    logic     pwr_evt;
    irq_evt_t evt;
    irq_evt_t flag_d;
    logic     req_norm;
    logic     req_bkup;

    // Previous power-fail level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_prev <= 1'b0;
        else        pwr_prev <= pwr_fail;
    end

    // Collect this cycle's events.
    always_comb begin
        pwr_evt = pwr_fail & ~pwr_prev;
        evt.alm = alm_evt;
        evt.per = per_evt;
        evt.pwr = pwr_evt;
    end

    // Next flag state: events set, a read clears, and an event beats a read.
    always_comb begin
        flag_d = flag_rd ? evt : (flag_q | evt);
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // Interrupt gating for normal and backup operation.
    always_comb begin
        req_norm = (flag_q.alm & en_alarm) | (flag_q.per & en_periodic)
                 | (flag_q.pwr & en_pwrfail);
        req_bkup = flag_q.alm & en_alarm & en_alm_backup;
        irq_pull = backup_mode ? req_bkup : req_norm;
    end

    // R7: a read with no alarm event leaves the alarm flag clear.
    p_rd_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !alm_evt) |=> !flag_q.alm);
    // R7: an event in a read cycle still sets its flag.
    p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && per_evt) |=> flag_q.per);
    // R5: one power-fail edge cannot be followed at once by another.
    p_pwr_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_evt |=> !pwr_evt);
    // R9: in backup mode, no pull without alarm-in-backup enabled.
    p_backup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_mode && !en_alm_backup) |-> !irq_pull);
    // R8: with every enable cleared, the line is never pulled.
    p_no_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_alarm && !en_periodic && !en_pwrfail) |-> !irq_pull);
endmodule

// File: rtl/rtc_irq_ctrl.sv
// RTC interrupt controller top.
// Connects the alarm comparator, the periodic timer and the flag/interrupt
// stage, and assembles the flag byte.
// Assumes all inputs are synchronous to clk.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       upd_pulse,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_date,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_date,
    input  logic [3:0] rate_sel,
    input  logic       en_alarm,
    input  logic       en_periodic,
    input  logic       en_pwrfail,
    input  logic       en_alm_backup,
    input  logic       pwr_fail,
    input  logic       backup_mode,
    input  logic       batt_valid,
    input  logic       flag_rd,
    output logic [7:0] flags,
    output logic       irq_pull
);
    logic [NUM_ALM-1:0][BYTE_W-1:0] cur_bytes;
    logic [NUM_ALM-1:0][BYTE_W-1:0] alm_bytes;
    logic                           alm_evt;
    logic                           per_evt;
    irq_evt_t                       flag_q;

    // Pack the time and alarm bytes for the comparator.
    always_comb begin
        cur_bytes = {cur_date, cur_hour, cur_min, cur_sec};
        alm_bytes = {alm_date, alm_hour, alm_min, alm_sec};
    end

    rtc_alarm_match #(.NB(NUM_ALM), .W(BYTE_W)) alarm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_pulse (upd_pulse),
        .cur_bytes (cur_bytes),
        .alm_bytes (alm_bytes),
        .alm_evt   (alm_evt)
    );

    rtc_periodic_timer #(.RW(RATE_W), .CW(PER_CNT_W)) per_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_32k (tick_32k),
        .rate_sel (rate_sel),
        .per_evt  (per_evt)
    );

    rtc_flag_irq flag_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .alm_evt       (alm_evt),
        .per_evt       (per_evt),
        .pwr_fail      (pwr_fail),
        .flag_rd       (flag_rd),
        .en_alarm      (en_alarm),
        .en_periodic   (en_periodic),
        .en_pwrfail    (en_pwrfail),
        .en_alm_backup (en_alm_backup),
        .backup_mode   (backup_mode),
        .flag_q        (flag_q),
        .irq_pull      (irq_pull)
    );

    // Assemble the flag byte.
    always_comb begin
        flags           = '0;
        flags[FLAG_ALM] = flag_q.alm;
        flags[FLAG_PER] = flag_q.per;
        flags[FLAG_PWR] = flag_q.pwr;
        flags[FLAG_BAT] = batt_valid;
    end

    // R10: the line is released in the cycle after reset.
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !irq_pull);
endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0, upd_pulse = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0, alm_date = '0;
    logic [3:0] rate_sel = '0;
    logic       en_alarm = 0, en_periodic = 0, en_pwrfail = 0, en_alm_backup = 0;
    logic       pwr_fail = 0, backup_mode = 0, batt_valid = 1, flag_rd = 0;
    logic [7:0] flags;
    logic       irq_pull;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rtc_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .upd_pulse(upd_pulse),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_date(alm_date),
        .rate_sel(rate_sel), .en_alarm(en_alarm), .en_periodic(en_periodic),
        .en_pwrfail(en_pwrfail), .en_alm_backup(en_alm_backup), .pwr_fail(pwr_fail),
        .backup_mode(backup_mode), .batt_valid(batt_valid), .flag_rd(flag_rd),
        .flags(flags), .irq_pull(irq_pull)
    );

    // Alarm vectors: cur{sec,min,hour,date}, alm{sec,min,hour,date}, expected match.
    localparam logic [64:0] VEC [0:9] = '{
        {32'h15_12_34_56, 32'hFF_FF_FF_FF, 1'b1},  // all masked
        {32'h15_12_34_56, 32'hFF_FF_FF_56, 1'b1},  // seconds match
        {32'h15_12_34_56, 32'hFF_FF_FF_57, 1'b0},  // seconds differ
        {32'h15_12_34_56, 32'hFF_FF_34_56, 1'b1},  // min+sec match
        {32'h15_12_34_56, 32'hFF_FF_35_56, 1'b0},  // minute differs
        {32'h15_12_34_56, 32'hFF_12_34_56, 1'b1},  // hour+min+sec
        {32'h15_12_34_56, 32'h15_12_34_56, 1'b1},  // full match
        {32'h15_12_34_56, 32'h16_12_34_56, 1'b0},  // date differs
        {32'h15_92_34_00, 32'hC0_92_C0_80, 1'b0},  // bit 7 alone does not mask
        {32'h15_92_34_40, 32'hC0_92_C0_40, 1'b1}   // bit 6 alone does not mask
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        flag_rd = 1'b1;
        step();
        flag_rd = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R10: reset state; R6: battery bit follows input, upper bits zero.
        chk("R10 flags after reset", flags, 8'h01);
        chk("R10 irq after reset", {7'd0, irq_pull}, 8'h00);
        rst_n = 1'b1;
        step();
        chk("R10 flags after release", flags, 8'h01);

        // R1/R2: walk the alarm vector table.
        for (int i = 0; i < 10; i++) begin
            {cur_date, cur_hour, cur_min, cur_sec} = VEC[i][64:33];
            {alm_date, alm_hour, alm_min, alm_sec} = VEC[i][32:1];
            upd_pulse = 1'b1;
            step();
            upd_pulse = 1'b0;
            chk($sformatf("R1 R2 alarm vector %0d", i), {7'd0, flags[3]}, {7'd0, VEC[i][0]});
            clear_flags();
        end

        // R2: a matching alarm without an update pulse does not set the flag.
        {alm_date, alm_hour, alm_min, alm_sec} = 32'hFFFF_FFFF;
        step();
        step();
        chk("R2 no update no flag", flags, 8'h01);

        // R4: code 0 never fires.
        rate_sel = 4'd0;
        tick_32k = 1'b1;
        repeat (40) step();
        chk("R4 code 0 silent", flags, 8'h01);

        // R3: code 1 fires on every tick.
        rate_sel = 4'd1;
        step();
        tick_32k = 1'b0;
        chk("R3 code 1 first tick", flags, 8'h05);
        clear_flags();
        chk("R7 read clears periodic", flags, 8'h01);

        // R3: code 3 fires on the fourth tick.
        rate_sel = 4'd0;
        step();
        rate_sel = 4'd3;
        tick_32k = 1'b1;
        repeat (3) step();
        chk("R3 code 3 before fourth tick", flags, 8'h01);
        step();
        chk("R3 code 3 fourth tick", flags, 8'h05);
        tick_32k = 1'b0;
        clear_flags();

        // R3: code 15 fires on tick 16384.
        rate_sel = 4'd0;
        step();
        rate_sel = 4'd15;
        tick_32k = 1'b1;
        repeat (16383) step();
        chk("R3 code 15 before limit", flags, 8'h01);
        step();
        chk("R3 code 15 at limit", flags, 8'h05);
        tick_32k = 1'b0;
        rate_sel = 4'd0;
        clear_flags();

        // R5: power-fail edge sets the flag once.
        pwr_fail = 1'b1;
        step();
        chk("R5 power-fail edge", flags, 8'h03);
        clear_flags();
        repeat (5) step();
        chk("R5 held high no re-set", flags, 8'h01);

        // R7: an event in a read cycle wins; other flags clear.
        pwr_fail = 1'b0;
        upd_pulse = 1'b1;
        step();
        upd_pulse = 1'b0;
        chk("R2 alarm set before race", flags, 8'h09);
        pwr_fail = 1'b1;
        flag_rd = 1'b1;
        step();
        flag_rd = 1'b0;
        chk("R7 event beats read", flags, 8'h03);

        // R8: enables gate the line.
        chk("R8 no enable no irq", {7'd0, irq_pull}, 8'h00);
        en_pwrfail = 1'b1;
        #0.5;
        chk("R8 power-fail enabled", {7'd0, irq_pull}, 8'h01);
        en_pwrfail = 1'b0;
        en_alarm = 1'b1;
        en_periodic = 1'b1;
        #0.5;
        chk("R8 unrelated enables", {7'd0, irq_pull}, 8'h00);

        // R6: battery bit follows input and survives a read.
        batt_valid = 1'b0;
        clear_flags();
        chk("R6 battery low and read", flags, 8'h00);
        batt_valid = 1'b1;
        flag_rd = 1'b1;
        step();
        flag_rd = 1'b0;
        chk("R6 battery bit not cleared", flags, 8'h01);

        // R9: backup mode gating.
        en_pwrfail = 1'b1;
        pwr_fail = 1'b0;
        step();
        pwr_fail = 1'b1;
        step();
        backup_mode = 1'b1;
        #0.5;
        chk("R9 power-fail released in backup", {7'd0, irq_pull}, 8'h00);
        upd_pulse = 1'b1;
        step();
        upd_pulse = 1'b0;
        chk("R9 alarm without backup enable", {7'd0, irq_pull}, 8'h00);
        en_alm_backup = 1'b1;
        #0.5;
        chk("R9 alarm with backup enable", {7'd0, irq_pull}, 8'h01);
        en_alarm = 1'b0;
        #0.5;
        chk("R9 alarm enable cleared", {7'd0, irq_pull}, 8'h00);
        backup_mode = 1'b0;
        #0.5;
        chk("R8 back in normal mode", {7'd0, irq_pull}, 8'h01);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule